// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block keeps the interrupt state of a single DMA channel. It watches the channel's programmed transfer length, its live remaining count, a block-done strobe from the transfer engine and an error strobe from the bus master. From these it keeps four sticky flags: block done, bus-error abort, wraparound complete and wraparound half-complete. A qualified interrupt line is driven from those flags. Software reads the flags through one 32-bit status word and clears any flag by writing a one to its bit.

A bus error also raises a halt request to the transfer engine. The request stays high until software pulses the channel reset input, so the engine stays idle until it is restarted. The wraparound flags come from comparing the remaining count with zero and with half the programmed length. Each one sets only on the cycle its comparison turns true, so a flag cleared while the count is parked does not set again at once.

Top module: `dma_irq_status`

## Requirements
- R1: While reset is asserted and after it is released, the status word, `irq` and `halt_req` are all zero. A remaining count that already meets a wraparound condition when reset is released sets no flag.
- R2: A one-cycle `blk_done` pulse sets status bit 1 in the next cycle. The bit reads 0 until a block completes.
- R3: A `bus_err` pulse sets status bit 0 (abort) and raises `halt_req` in the next cycle.
- R4: `halt_req` stays high, even after the abort flag is cleared, until a `chan_rst` pulse clears it in the next cycle. If `bus_err` and `chan_rst` arrive together, `halt_req` is set.
- R5: Status bit 8 (wraparound complete) sets in the cycle after `xfer_remain` becomes zero. It does not set again while the count stays zero.
- R6: Status bit 10 (wraparound half) sets in the cycle after `xfer_remain` becomes equal to `xfer_total >> 1`, so an odd length rounds down. It does not set again while the count is unchanged.
- R7: A register write with a one in a flag's bit (0, 1, 8 or 10) clears that flag in the next cycle. A zero in that bit leaves the flag unchanged.
- R8: If a flag's set event and a write-one clear of that flag occur in the same cycle, the flag reads 1 afterwards.
- R9: `irq` is the OR of each flag ANDed with its enable, using `flag_en` bit 0 for abort, bit 1 for done, bit 2 for wraparound complete and bit 3 for wraparound half. Status bit 31 always equals `irq`, and every other bit of the status word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_total | input | CNT_W | Programmed transfer length |
| xfer_remain | input | CNT_W | Live remaining transfer count |
| blk_done | input | 1 | Block transfer complete strobe |
| bus_err | input | 1 | Error response strobe from the bus master |
| chan_rst | input | 1 | Software channel reset pulse; releases the halt |
| flag_en | input | 4 | Per-flag interrupt enables |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 32 | Write data; ones clear flags |
| rd_data | output | 32 | Status word |
| irq | output | 1 | Channel interrupt line |
| halt_req | output | 1 | Request to the transfer engine to stop and stay idle |

## Verification
The assertions assume that `xfer_total` and `xfer_remain` change only between clock edges. They also assume that any rise of a wraparound flag can be traced to the counts seen one cycle earlier, which means the counts must not meet the condition in the reset cycle and then move away from it. The stimulus drives every input on the falling edge and parks the remaining count at a value that matches neither condition before each trial. It moves the count down by one per cycle, so every flag rise follows a single, visible change of the count.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int NFLAG  = 4;
    localparam int STAT_W = 32;
    localparam int IRQ_BIT = 31;

    // Flag index order, shared by the flag array and the enable input.
    localparam int F_ABORT     = 0;
    localparam int F_DONE      = 1;
    localparam int F_WRAP_END  = 2;
    localparam int F_WRAP_HALF = 3;

    // Status-word bit position of each flag.
    function automatic int flag_bit(input int idx);
        case (idx)
            F_ABORT:     return 0;
            F_DONE:      return 1;
            F_WRAP_END:  return 8;
            default:     return 10;
        endcase
    endfunction

    typedef struct packed {
        logic seen;
    } edge_st_t;

    typedef struct packed {
        logic halt;
    } ctl_st_t;

endpackage

// File: rtl/dma_irq_edge.sv
// Turns a level condition into a one-cycle rise pulse. The history bit
// resets to one, so a condition already true at reset release is ignored.
module dma_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic rise
);
    import dma_irq_pkg::*;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = cond;
        rise      = cond & ~st_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seen: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dma_irq_flag.sv
// Sticky write-one-to-clear flag; a set in the same cycle beats the clear.
module dma_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    logic q_d, q_q;

    always_comb begin
        q_d = set | (q_q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [CNT_W-1:0]                  xfer_total,
    input  logic [CNT_W-1:0]                  xfer_remain,
    input  logic                              blk_done,
    input  logic                              bus_err,
    input  logic                              chan_rst,
    input  logic [dma_irq_pkg::NFLAG-1:0]     flag_en,
    input  logic                              wr_en,
    input  logic [dma_irq_pkg::STAT_W-1:0]    wr_data,
    output logic [dma_irq_pkg::STAT_W-1:0]    rd_data,
    output logic                              irq,
    output logic                              halt_req
);
    import dma_irq_pkg::*;

    localparam int NWRAP = 2;

    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flags;
    logic [NWRAP-1:0] wrap_cond;
    logic [NWRAP-1:0] wrap_rise;
    logic [CNT_W-1:0] half_mark;

    // Wraparound comparisons: index 0 -> count reached zero, 1 -> halfway.
    assign half_mark    = xfer_total >> 1;
    assign wrap_cond[0] = (xfer_remain == '0);
    assign wrap_cond[1] = (xfer_remain == half_mark);

    for (genvar w = 0; w < NWRAP; w++) begin : g_wrap
        dma_irq_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .cond (wrap_cond[w]),
            .rise (wrap_rise[w])
        );
    end

    always_comb begin
        flag_set              = '0;
        flag_set[F_ABORT]     = bus_err;
        flag_set[F_DONE]      = blk_done;
        flag_set[F_WRAP_END]  = wrap_rise[0];
        flag_set[F_WRAP_HALF] = wrap_rise[1];
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam int BP = flag_bit(i);
        assign flag_clr[i] = wr_en & wr_data[BP];
        dma_irq_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (flag_set[i]),
            .clr  (flag_clr[i]),
            .q    (flags[i])
        );
    end

    // Halt control toward the transfer engine.
    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_err)       st_d.halt = 1'b1;
        else if (chan_rst) st_d.halt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{halt: 1'b0};
        else        st_q <= st_d;
    end

    assign halt_req = st_q.halt;
    assign irq      = |(flags & flag_en);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NFLAG; i++) begin
            rd_data[flag_bit(i)] = flags[i];
        end
        rd_data[IRQ_BIT] = irq;
    end

    // Only flag bit positions of the write word are decoded.
    logic unused_wr;
    assign unused_wr = ^wr_data;
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] xfer_total,
    input logic [CNT_W-1:0] xfer_remain,
    input logic             blk_done,
    input logic             bus_err,
    input logic             chan_rst,
    input logic [3:0]       flag_en,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic             irq,
    input logic             halt_req
);
    localparam logic [31:0] FLAG_MASK = 32'h8000_0503;

    assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> rd_data[1]);

    assert_abort_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> (rd_data[0] && halt_req));

    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !chan_rst) |=> halt_req);

    assert_halt_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst && !bus_err) |=> !halt_req);

    assert_wrap_end_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[8]) |-> ($past(xfer_remain) == '0));

    assert_wrap_half_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[10]) |-> ($past(xfer_remain) == ($past(xfer_total) >> 1)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && !blk_done) |=> !rd_data[1]);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] && !(wr_en && wr_data[1])) |=> rd_data[1]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && wr_en && wr_data[0]) |=> rd_data[0]);

    assert_irq_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31] == irq) &&
        (irq == |({rd_data[10], rd_data[8], rd_data[1], rd_data[0]} & flag_en)));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~FLAG_MASK) == 32'h0);
endmodule

bind dma_irq_status dma_irq_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_total (xfer_total),
    .xfer_remain(xfer_remain),
    .blk_done   (blk_done),
    .bus_err    (bus_err),
    .chan_rst   (chan_rst),
    .flag_en    (flag_en),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .irq        (irq),
    .halt_req   (halt_req)
);

// File: tb/dma_irq_status_tb.sv
`timescale 1ns/1ps
module dma_irq_status_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] xfer_total;
    logic [CNT_W-1:0] xfer_remain;
    logic             blk_done;
    logic             bus_err;
    logic             chan_rst;
    logic [3:0]       flag_en;
    logic             wr_en;
    logic [31:0]      wr_data;
    logic [31:0]      rd_data;
    logic             irq;
    logic             halt_req;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_irq_status #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_total(xfer_total),
        .xfer_remain(xfer_remain), .blk_done(blk_done), .bus_err(bus_err),
        .chan_rst(chan_rst), .flag_en(flag_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .halt_req(halt_req)
    );

    // Flag order a,d,e,h = abort(bit0), done(bit1), end(bit8), half(bit10).
    function automatic logic [31:0] stat(input logic [3:0] f, input logic iv);
        logic [31:0] s;
        s = '0;
        s[0] = f[0]; s[1] = f[1]; s[8] = f[2]; s[10] = f[3]; s[31] = iv;
        return s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_all();
        xfer_total = 8; xfer_remain = 9; tick();
        xfer_remain = 4; tick();
        xfer_remain = 0; blk_done = 1'b1; bus_err = 1'b1; tick();
        blk_done = 1'b0; bus_err = 1'b0; chan_rst = 1'b1; tick();
        chan_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; xfer_total = '0; xfer_remain = '0; blk_done = 1'b0;
        bus_err = 1'b0; chan_rst = 1'b0; flag_en = 4'hF; wr_en = 1'b0; wr_data = '0;
        repeat (3) tick();
        // R1: reset state while reset held
        check("R1 status in reset", rd_data, 32'h0);
        check("R1 irq/halt in reset", {30'h0, irq, halt_req}, 32'h0);
        rst_n = 1'b1;
        repeat (2) tick();
        // R1: count already zero and already at half at release sets nothing
        check("R1 no flag after release", rd_data, 32'h0);
        check("R1 halt after release", {31'h0, halt_req}, 32'h0);

        // R2: block done sets bit 1
        xfer_remain = 5; xfer_total = 20; tick();
        check("R2 idle reads 0", rd_data, 32'h0);
        blk_done = 1'b1; tick(); blk_done = 1'b0;
        check("R2 done set", rd_data, stat(4'b0010, 1'b1));
        repeat (3) tick();
        check("R2 done sticky", rd_data, stat(4'b0010, 1'b1));
        // R7: write zero leaves it, write one clears
        wr(32'hFFFF_F0FD); tick();
        check("R7 write zero no effect", rd_data, stat(4'b0010, 1'b1));
        wr(32'h0000_0002);
        check("R7 write one clears", rd_data, 32'h0);
        // R8: set and clear together
        blk_done = 1'b1; wr_en = 1'b1; wr_data = 32'h2; tick();
        blk_done = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R8 done set beats clear", rd_data, stat(4'b0010, 1'b1));
        wr(32'h2);

        // R3/R4: abort and halt
        bus_err = 1'b1; tick(); bus_err = 1'b0;
        check("R3 abort flag", rd_data, stat(4'b0001, 1'b1));
        check("R3 halt raised", {31'h0, halt_req}, 32'h1);
        repeat (4) tick();
        check("R4 halt held", {31'h0, halt_req}, 32'h1);
        wr(32'h1);
        check("R7 abort cleared", rd_data, 32'h0);
        check("R4 halt held after flag clear", {31'h0, halt_req}, 32'h1);
        chan_rst = 1'b1; tick(); chan_rst = 1'b0;
        check("R4 halt released", {31'h0, halt_req}, 32'h0);
        bus_err = 1'b1; chan_rst = 1'b1; wr_en = 1'b1; wr_data = 32'h1; tick();
        bus_err = 1'b0; chan_rst = 1'b0; wr_en = 1'b0; wr_data = '0;
        check("R4 error beats channel reset", {31'h0, halt_req}, 32'h1);
        check("R8 abort set beats clear", rd_data, stat(4'b0001, 1'b1));
        chan_rst = 1'b1; tick(); chan_rst = 1'b0;
        check("R4 halt released again", {31'h0, halt_req}, 32'h0);
        wr(32'h1);

        // R5/R6: sweep programmed lengths, count down one per cycle
        flag_en = 4'h0;
        for (int t = 0; t <= 24; t++) begin
            logic half_seen, end_seen;
            half_seen = 1'b0; end_seen = 1'b0;
            xfer_total = CNT_W'(t); xfer_remain = CNT_W'(t + 1);
            wr(32'h0000_0503);
            check("R5/R6 parked count no flag", rd_data, 32'h0);
            for (int v = t; v >= 0; v--) begin
                xfer_remain = CNT_W'(v); tick();
                if (v == (t >> 1)) half_seen = 1'b1;
                if (v == 0) end_seen = 1'b1;
                check("R6 half flag", {31'h0, rd_data[10]}, {31'h0, half_seen});
                check("R5 end flag", {31'h0, rd_data[8]}, {31'h0, end_seen});
            end
            wr(32'h0000_0500);
            repeat (2) tick();
            check("R5/R6 no re-set on unchanged count", rd_data, 32'h0);
        end

        // R9: every flag pattern against every enable pattern
        for (int p = 0; p < 16; p++) begin
            set_all();
            check("R9 all flags set", rd_data & 32'h0000_0503, 32'h0000_0503);
            wr(stat(~4'(p), 1'b0));
            for (int e = 0; e < 16; e++) begin
                logic exp_irq;
                flag_en = 4'(e);
                #1;
                exp_irq = |(4'(p) & 4'(e));
                check("R9 status and irq", rd_data, stat(4'(p), exp_irq));
                check("R9 irq line", {31'h0, irq}, {31'h0, exp_irq});
            end
            tick();
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule